// File: doc/BRIEF.md
# Dimming Pulse Request Sequencer

This block sits on the controller side of an LED driver and produces a programmed number of discrete light pulses inside one bit slice, so that very low brightness levels can be reached. A one-cycle start strobe opens a slice. The block latches a pulse count and two delays, raises the drive-enable request and keeps the shunt path active for a charge window. It then releases the shunt so that current flows through the LED. It waits for the driver's active-low completion flag, closes the shunt again and holds an off window. After the off window it either requests the next pulse or ends the slice.

The block counts completed pulses itself. A pulse count of zero ends the slice at once. A watchdog limits how long the block waits for the completion flag, and a timeout aborts the slice with an error flag. A start strobe that arrives while a slice is running is dropped and leaves a sticky overrun flag. All outputs are registered.

Top module: `dimming_pulse_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `drv_en`=0, `shunt_n`=1, `busy`=0, `slice_done`=0, `fault`=0 and `overrun`=0.
- R2: A `slice_start` sampled while `busy`=0 with a nonzero `pulse_cnt` gives `drv_en`=1, `shunt_n`=1 and `busy`=1 in the next cycle, and `fault` is cleared.
- R3: After `drv_en` rises, `shunt_n` stays 1 for exactly `charge_dly`+1 cycles and then falls. `shunt_n` is never 0 while `drv_en` is 0.
- R4: While `shunt_n`=0, a `done_n`=0 sampled at a clock edge makes `shunt_n`=1 in the next cycle. `done_n` has no effect while `shunt_n`=1.
- R5: After a pulse completes, `shunt_n` stays 1 with `drv_en`=1 for exactly `off_dly`+1 cycles.
- R6: The slice contains exactly `pulse_cnt` shunt-low periods. After the last off window, `drv_en` drops, `busy` drops and `slice_done` is 1 for a single cycle.
- R7: A start with `pulse_cnt`=0 gives `slice_done`=1 in the next cycle, and `drv_en` and `busy` stay 0.
- R8: If `shunt_n` has been 0 for `WDOG_CYC` cycles and `done_n` was never sampled low, then in the next cycle `drv_en`=0, `shunt_n`=1, `busy`=0, `fault`=1 and `slice_done`=0. A `done_n`=0 sampled at that final edge counts as a normal completion.
- R9: A `slice_start` sampled while `busy`=1 does not disturb the running slice. It sets `overrun` in the next cycle, and `overrun` then stays 1 until reset.
- R10: `fault` stays 1 until the next accepted start strobe.
- R11: `pulse_cnt`, `charge_dly` and `off_dly` are sampled only at the accepted start. Changing them during a slice has no effect on that slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slice_start | input | 1 | One-cycle strobe that opens a bit slice |
| pulse_cnt | input | CNT_W | Number of light pulses in the slice |
| charge_dly | input | TMR_W | Charge window length minus one, in cycles |
| off_dly | input | TMR_W | Off window length minus one, in cycles |
| done_n | input | 1 | Pulse-complete flag from the driver, active low |
| drv_en | output | 1 | Drive-enable request |
| shunt_n | output | 1 | Shunt enable: 1 keeps the shunt active, 0 routes current through the LED |
| busy | output | 1 | A slice is in progress |
| slice_done | output | 1 | One-cycle pulse when a slice ends normally |
| fault | output | 1 | Completion watchdog expired |
| overrun | output | 1 | Sticky flag: a start arrived while busy |

## Verification
Every output is one register away from its cause. A start sampled at an edge therefore shows on `drv_en` in the following cycle, and a completion flag sampled at an edge shows on `shunt_n` in the following cycle. The charge and off windows last their delay plus one cycle, and a timeout follows exactly `WDOG_CYC` low cycles. The bench drives its inputs and samples the outputs on falling edges. It counts the length of each window in whole cycles and compares it with these sums, and it checks the end-of-slice flags in the cycle right after the last window closes. Stray completion pulses during the windows, parameter changes in mid-slice and a completion on the final watchdog edge are aimed at the exact edges where a wrong design would react.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHARGE = 2'd1,
        ST_LIGHT  = 2'd2,
        ST_OFF    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dps_timer.sv
// Loadable down-counter; zero flag reflects the registered count.
module dps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (run && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero = (tmr_q.cnt == '0);

endmodule

// File: rtl/dps_pulse_tally.sv
// Holds the latched pulse target and the number of completed pulses.
module dps_pulse_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] target_in,
    input  logic             inc,
    output logic             reached
);
    typedef struct packed {
        logic [CNT_W-1:0] target;
        logic [CNT_W-1:0] count;
    } tally_s;

    tally_s tal_d, tal_q;

    always_comb begin
        tal_d = tal_q;
        if (load) begin
            tal_d.target = target_in;
            tal_d.count  = '0;
        end else if (inc) begin
            tal_d.count = tal_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tal_q <= '0;
        end else begin
            tal_q <= tal_d;
        end
    end

    assign reached = (tal_q.count == tal_q.target);

endmodule

// File: rtl/dimming_pulse_seq.sv
module dimming_pulse_seq
    import dps_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int TMR_W    = 12,
    parameter int WDOG_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slice_start,
    input  logic [CNT_W-1:0] pulse_cnt,
    input  logic [TMR_W-1:0] charge_dly,
    input  logic [TMR_W-1:0] off_dly,
    input  logic             done_n,
    output logic             drv_en,
    output logic             shunt_n,
    output logic             busy,
    output logic             slice_done,
    output logic             fault,
    output logic             overrun
);
    localparam int WD_W = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
    localparam logic [WD_W-1:0] WD_RELOAD = WD_W'(WDOG_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [TMR_W-1:0] off_lat;
        logic             drv_en;
        logic             shunt_n;
        logic             busy;
        logic             slice_done;
        logic             fault;
        logic             overrun;
    } seq_s;

    localparam seq_s SEQ_RESET = '{
        state:      ST_IDLE,
        off_lat:    '0,
        drv_en:     1'b0,
        shunt_n:    1'b1,
        busy:       1'b0,
        slice_done: 1'b0,
        fault:      1'b0,
        overrun:    1'b0
    };

    seq_s seq_d, seq_q;

    logic             win_load;
    logic [TMR_W-1:0] win_val;
    logic             win_run;
    logic             win_zero;
    logic             wd_load;
    logic             wd_run;
    logic             wd_zero;
    logic             tal_load;
    logic             tal_inc;
    logic             tal_reached;

    // Charge and off windows share one timer; they never overlap.
    dps_timer #(.W(TMR_W)) u_win_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (win_val),
        .run      (win_run),
        .zero     (win_zero)
    );

    dps_timer #(.W(WD_W)) u_wd_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (wd_load),
        .load_val (WD_RELOAD),
        .run      (wd_run),
        .zero     (wd_zero)
    );

    dps_pulse_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .load      (tal_load),
        .target_in (pulse_cnt),
        .inc       (tal_inc),
        .reached   (tal_reached)
    );

    always_comb begin
        seq_d            = seq_q;
        seq_d.slice_done = 1'b0;
        win_load         = 1'b0;
        win_val          = charge_dly;
        win_run          = 1'b0;
        wd_load          = 1'b0;
        wd_run           = 1'b0;
        tal_load         = 1'b0;
        tal_inc          = 1'b0;

        if (slice_start && (seq_q.state != ST_IDLE)) begin
            seq_d.overrun = 1'b1;
        end

        unique case (seq_q.state)
            ST_IDLE: begin
                if (slice_start) begin
                    seq_d.fault   = 1'b0;
                    seq_d.off_lat = off_dly;
                    tal_load      = 1'b1;
                    if (pulse_cnt == '0) begin
                        seq_d.slice_done = 1'b1;
                    end else begin
                        seq_d.state   = ST_CHARGE;
                        seq_d.drv_en  = 1'b1;
                        seq_d.shunt_n = 1'b1;
                        seq_d.busy    = 1'b1;
                        win_load      = 1'b1;
                        win_val       = charge_dly;
                    end
                end
            end
            ST_CHARGE: begin
                win_run = 1'b1;
                if (win_zero) begin
                    seq_d.state   = ST_LIGHT;
                    seq_d.shunt_n = 1'b0;
                    wd_load       = 1'b1;
                end
            end
            ST_LIGHT: begin
                wd_run = 1'b1;
                if (!done_n) begin
                    seq_d.state   = ST_OFF;
                    seq_d.shunt_n = 1'b1;
                    tal_inc       = 1'b1;
                    win_load      = 1'b1;
                    win_val       = seq_q.off_lat;
                end else if (wd_zero) begin
                    seq_d.state   = ST_IDLE;
                    seq_d.drv_en  = 1'b0;
                    seq_d.shunt_n = 1'b1;
                    seq_d.busy    = 1'b0;
                    seq_d.fault   = 1'b1;
                end
            end
            ST_OFF: begin
                win_run = 1'b1;
                if (win_zero) begin
                    if (tal_reached) begin
                        seq_d.state      = ST_IDLE;
                        seq_d.drv_en     = 1'b0;
                        seq_d.busy       = 1'b0;
                        seq_d.slice_done = 1'b1;
                    end else begin
                        seq_d.state   = ST_LIGHT;
                        seq_d.shunt_n = 1'b0;
                        wd_load       = 1'b1;
                    end
                end
            end
            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drv_en     = seq_q.drv_en;
    assign shunt_n    = seq_q.shunt_n;
    assign busy       = seq_q.busy;
    assign slice_done = seq_q.slice_done;
    assign fault      = seq_q.fault;
    assign overrun    = seq_q.overrun;

endmodule

// File: rtl/dps_checker.sv
module dps_checker (
    input logic clk,
    input logic rst,
    input logic slice_start,
    input logic done_n,
    input logic drv_en,
    input logic shunt_n,
    input logic busy,
    input logic slice_done,
    input logic fault,
    input logic overrun
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!drv_en && shunt_n && !busy && !slice_done && !fault && !overrun));

    // R2
    drive_rise_shunt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> (shunt_n && busy));

    // R3
    shunt_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !shunt_n |-> drv_en);

    // R4
    complete_closes_shunt_chk: assert property (@(posedge clk) disable iff (rst)
        (!shunt_n && !done_n) |=> shunt_n);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        slice_done |=> !slice_done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        slice_done |-> (!drv_en && !busy && shunt_n));

    // R8
    fault_safe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> (!drv_en && shunt_n && !busy && !slice_done));

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && slice_start) |=> overrun);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !(slice_start && !busy)) |=> fault);

endmodule

bind dimming_pulse_seq dps_checker u_dps_checker (
    .clk         (clk),
    .rst         (rst),
    .slice_start (slice_start),
    .done_n      (done_n),
    .drv_en      (drv_en),
    .shunt_n     (shunt_n),
    .busy        (busy),
    .slice_done  (slice_done),
    .fault       (fault),
    .overrun     (overrun)
);

// File: tb/tb_dimming_pulse_seq.sv
`timescale 1ns/1ps
module tb_dimming_pulse_seq;
    localparam int CNT_W = 4;
    localparam int TMR_W = 4;
    localparam int WDOG  = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             slice_start = 1'b0;
    logic [CNT_W-1:0] pulse_cnt = '0;
    logic [TMR_W-1:0] charge_dly = '0;
    logic [TMR_W-1:0] off_dly = '0;
    logic             done_n = 1'b1;
    logic             drv_en, shunt_n, busy, slice_done, fault, overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dimming_pulse_seq #(.CNT_W(CNT_W), .TMR_W(TMR_W), .WDOG_CYC(WDOG)) dut (
        .clk(clk), .rst(rst), .slice_start(slice_start), .pulse_cnt(pulse_cnt),
        .charge_dly(charge_dly), .off_dly(off_dly), .done_n(done_n),
        .drv_en(drv_en), .shunt_n(shunt_n), .busy(busy), .slice_done(slice_done),
        .fault(fault), .overrun(overrun)
    );

    function automatic int exp_charge(input int c); return c + 1; endfunction
    function automatic int exp_off(input int o);    return o + 1; endfunction
    function automatic int exp_light_max();         return WDOG;  endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {26'd0, drv_en, shunt_n, busy, slice_done, fault, overrun};
    endfunction

    // R11: scramble the live inputs once the slice has been accepted
    task automatic scramble();
        pulse_cnt  = CNT_W'($urandom);
        charge_dly = TMR_W'($urandom);
        off_dly    = TMR_W'($urandom);
    endtask

    task automatic run_slice(input int n, input int c, input int o, input int lat,
                             input bit noise, input bit ovr);
        int cnt;
        slice_start = 1'b1; pulse_cnt = CNT_W'(n);
        charge_dly = TMR_W'(c); off_dly = TMR_W'(o); done_n = 1'b1;
        @(negedge clk);
        slice_start = 1'b0;
        scramble();
        if (n == 0) begin
            // R7: empty slice ends at once
            chk(!drv_en && slice_done && !busy, "R7", outs(), 6'b010100);
            @(negedge clk);
            chk(!drv_en && !slice_done && !busy, "R7", outs(), 6'b010000);
            return;
        end
        // R2 and R10: start accepted, fault cleared
        chk(drv_en && shunt_n && busy, "R2", outs(), 6'b111000);
        chk(!fault, "R10", fault, 0);
        cnt = 1;
        while (shunt_n && drv_en && cnt < 300) begin
            done_n = !(noise && cnt < c);
            @(negedge clk);
            if (shunt_n) cnt++;
        end
        done_n = 1'b1;
        // R3 (R4: stray done_n in the charge window ignored)
        chk(cnt == exp_charge(c) && !shunt_n, "R3", cnt, exp_charge(c));
        for (int p = 1; p <= n; p++) begin
            repeat (lat) @(negedge clk);
            chk(!shunt_n && drv_en, "R4", outs(), 6'b101000);
            done_n = 1'b0;
            @(negedge clk);
            done_n = 1'b1;
            chk(shunt_n && drv_en, "R4", outs(), 6'b111000);
            cnt = 1;
            while (shunt_n && drv_en && cnt < 300) begin
                done_n = !(noise && cnt < o);
                slice_start = ovr && (p == 1) && (cnt == 1);
                @(negedge clk);
                if (shunt_n && drv_en) cnt++;
            end
            slice_start = 1'b0;
            done_n = 1'b1;
            // R5 (and R11: live off_dly was scrambled)
            chk(cnt == exp_off(o), "R5", cnt, exp_off(o));
            if (ovr && p == 1) chk(overrun, "R9", overrun, 1);
            if (p < n)
                chk(!shunt_n && drv_en, "R6", outs(), 6'b101000);
            else
                chk(!drv_en && shunt_n && slice_done && !busy, "R6", outs(), 6'b010100);
        end
        @(negedge clk);
        chk(!slice_done && !drv_en && shunt_n, "R6", outs(), 6'b010000);
    endtask

    task automatic run_timeout(input int c);
        int cnt;
        slice_start = 1'b1; pulse_cnt = 4'd3; charge_dly = TMR_W'(c); done_n = 1'b1;
        @(negedge clk);
        slice_start = 1'b0;
        while (shunt_n && drv_en) @(negedge clk);
        cnt = 0;
        while (!shunt_n && cnt < 300) begin
            cnt++;
            @(negedge clk);
        end
        // R8: timeout after exactly the watchdog window
        chk(cnt == exp_light_max(), "R8", cnt, exp_light_max());
        chk(!drv_en && shunt_n && !busy && fault && !slice_done, "R8", outs(), 6'b010010);
        repeat (3) @(negedge clk);
        chk(fault && !drv_en, "R10", fault, 1);
    endtask

    task automatic idle_gap(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk(!drv_en && shunt_n && !busy, "R6", outs(), 6'b010000);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!drv_en && shunt_n && !busy && !slice_done && !fault && !overrun, "R1", outs(), 6'b010000);
        rst = 1'b0;
        @(negedge clk);
        chk(!drv_en && shunt_n && !busy, "R1", outs(), 6'b010000);

        // Directed corner cases
        run_slice(1, 0, 0, 0, 1'b0, 1'b0);
        run_slice(0, 3, 3, 0, 1'b0, 1'b0);             // R7
        run_slice(3, 5, 2, 1, 1'b1, 1'b0);             // R4 stray done_n
        run_slice(2, 2, 4, WDOG - 1, 1'b0, 1'b0);      // R8 completion on last edge wins
        run_slice(15, 1, 1, 0, 1'b0, 1'b0);            // max count
        run_timeout(2);                                // R8
        run_slice(2, 1, 3, 2, 1'b0, 1'b0);             // R10 cleared on start
        run_slice(3, 2, 3, 1, 1'b0, 1'b1);             // R9 overrun
        idle_gap(2);
        chk(overrun, "R9", overrun, 1);

        // Constrained random slices
        for (int t = 0; t < 60; t++) begin
            run_slice(int'($urandom_range(0, 6)), int'($urandom_range(0, 7)),
                      int'($urandom_range(0, 7)), int'($urandom_range(0, WDOG - 2)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) == 0));
            idle_gap(int'($urandom_range(0, 3)));
        end

        // R1: reset in the middle of a slice clears everything
        slice_start = 1'b1; pulse_cnt = 4'd4; charge_dly = 4'd1; off_dly = 4'd1;
        @(negedge clk);
        slice_start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!drv_en && shunt_n && !busy && !slice_done && !fault && !overrun, "R1", outs(), 6'b010000);
        rst = 1'b0;
        idle_gap(2);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule